// File: doc/BRIEF.md
# Sigma-Delta Result Offset and Gain Corrector

This block sits between the decimation filter of a sigma-delta converter and the logic that consumes its results. Each raw result that arrives with a valid strobe has the zero-scale coefficient taken away first. The difference is then scaled by the span coefficient, an unsigned fixed-point number. The product is rounded to a 24-bit or a 16-bit word, clipped to the range of the selected coding and delivered three clocks later with a one-cycle strobe. All intermediate arithmetic is wider than either output word, so nothing is lost before the final rounding.

The two coefficients can come from two places. A host can load either one through a single-word write port. Alternatively, the block can derive them from two captured readings. A zero-scale capture stores the current raw reading as the new offset. A full-scale capture divides the ideal full-scale code by the measured span and stores the quotient as the new gain. The full-scale capture runs as a bit-serial division of about fifty clocks. A second zero-scale capture on its own moves the zero point and leaves the gain as it is. Two codings are supported: unipolar, which reads raw words as unsigned and spans zero to full scale, and bipolar, which reads them as two's complement and spans midscale to positive full scale.

Top module: `adc_corr`

## Requirements
- R1: After reset `out_valid_o` and `out_data_o` are 0, the offset coefficient is 0 and the gain coefficient is 1.0 (0x400000), so a raw word passes through unchanged.
- R2: A raw word accepted on a rising edge with `raw_valid_i` high appears on `out_data_o` with `out_valid_o` high for exactly one cycle, three rising edges later; `out_valid_o` is never high otherwise.
- R3: In 24-bit mode (`narrow_i`=0) the output is floor(((x - o) * g + 2^21) / 2^22). Here x and o are the raw word and the offset, read as unsigned when `bipolar_i`=0 and as two's complement when `bipolar_i`=1, and g is the unsigned gain with 22 fraction bits.
- R4: In 16-bit mode (`narrow_i`=1) the output is floor(((x - o) * g + 2^29) / 2^30), placed in bits 15:0, with bits 23:16 zero.
- R5: The rounded value saturates instead of wrapping. In unipolar coding the limits are 0 and 2^N-1; in bipolar coding they are -2^(N-1) and 2^(N-1)-1, given as N-bit two's complement. N is 24 or 16.
- R6: A write with `reg_we_i`=1 loads `reg_wdata_i` into the offset when `reg_sel_i`=0 and into the gain when `reg_sel_i`=1. The other coefficient is untouched, and the new value applies to every raw word accepted after the write edge.
- R7: A pulse on `cal_zero_i` stores `raw_i` as the offset. The gain is unchanged. A host offset write in the same cycle takes priority.
- R8: A pulse on `cal_full_i` with span s = x - o > 0 sets the gain to floor(T * 2^22 / s), clamped to 0xFFFFFF. T is 2^24-1 in unipolar and 2^23-1 in bipolar coding. The new gain is in force within 50 cycles.
- R9: A pulse on `cal_full_i` whose span is zero or negative leaves the gain unchanged.
- R10: A host gain write while a full-scale computation is running cancels that computation, and the written gain remains.
- R11: Coefficients are taken together with each raw word at acceptance. A coefficient change on a later edge does not alter a result already in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bipolar_i | input | 1 | 1: two's complement coding, 0: unsigned coding |
| narrow_i | input | 1 | 1: 16-bit result, 0: 24-bit result |
| raw_valid_i | input | 1 | Raw word strobe |
| raw_i | input | 24 | Raw filter result, also the capture value for calibration |
| cal_zero_i | input | 1 | Capture raw_i as zero-scale reading |
| cal_full_i | input | 1 | Capture raw_i as full-scale reading and recompute gain |
| reg_we_i | input | 1 | Coefficient write enable |
| reg_sel_i | input | 1 | 0: offset, 1: gain |
| reg_wdata_i | input | 24 | Coefficient write value |
| out_valid_o | output | 1 | Corrected word strobe |
| out_data_o | output | 24 | Corrected, rounded and saturated word |

## Verification
The hardest case to reach is a host gain write that lands inside the fifty-cycle division. Only the later samples show whether the quotient or the written value won. The bench starts a full-scale capture whose quotient differs clearly from the value it writes a few cycles later, then waits past the division length and checks a sample against the written gain. A second hard case is the in-flight rule. Here the bench changes the gain on the edge just after a sample has been accepted and expects the result to use the old gain.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

    localparam int DEF_RAW_W     = 24;
    localparam int DEF_GAIN_W    = 24;
    localparam int DEF_GAIN_FRAC = 22;
    localparam int DEF_LO_W      = 16;

    typedef enum logic {
        SEL_OFFSET = 1'b0,
        SEL_GAIN   = 1'b1
    } coef_sel_e;

endpackage

// File: rtl/adc_corr_div.sv
module adc_corr_div #(
    parameter int DEN_W = 25,
    parameter int NUM_W = 46,
    parameter int Q_W   = 24
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cancel_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [Q_W-1:0]   quo_o
);

    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [NUM_W-1:0] num;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic             done;
        logic [Q_W-1:0]   res;
    } div_t;

    div_t q, d;
    logic [DEN_W:0]   trial;
    logic             qbit;
    logic [NUM_W-1:0] qn;

    always_comb begin
        d     = q;
        d.done = 1'b0;
        trial = {q.rem, q.num[NUM_W-1]};
        qbit  = (trial >= {1'b0, q.den});
        qn    = {q.quo[NUM_W-2:0], qbit};
        if (cancel_i) begin
            d.busy = 1'b0;
        end else if (start_i) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.num  = num_i;
            d.rem  = '0;
            d.quo  = '0;
            d.den  = den_i;
        end else if (q.busy) begin
            d.rem = qbit ? (trial[DEN_W-1:0] - q.den) : trial[DEN_W-1:0];
            d.num = q.num << 1;
            d.quo = qn;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(NUM_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.res  = (|qn[NUM_W-1:Q_W]) ? '1 : qn[Q_W-1:0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign busy_o = q.busy;
    assign done_o = q.done;
    assign quo_o  = q.res;

endmodule

// File: rtl/adc_corr_coef.sv
module adc_corr_coef
    import adc_corr_pkg::*;
#(
    parameter int RAW_W     = DEF_RAW_W,
    parameter int GAIN_W    = DEF_GAIN_W,
    parameter int GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int DATA_W    = (RAW_W > GAIN_W) ? RAW_W : GAIN_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bipolar_i,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic              cal_zero_i,
    input  logic              cal_full_i,
    input  logic              reg_we_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [RAW_W-1:0]  offset_o,
    output logic [GAIN_W-1:0] gain_o,
    output logic              div_busy_o,
    output logic              div_done_o
);

    localparam int EXT_W  = RAW_W + 1;
    localparam int SPAN_W = RAW_W + 2;
    localparam int DEN_W  = RAW_W + 1;
    localparam int NUM_W  = RAW_W + GAIN_FRAC;

    typedef struct packed {
        logic [RAW_W-1:0]  offset;
        logic [GAIN_W-1:0] gain;
    } coef_t;

    coef_t q, d;

    logic [EXT_W-1:0]  raw_e, off_e;
    logic [SPAN_W-1:0] span;
    logic              span_pos, host_off, host_gain, start;
    logic [RAW_W-1:0]  target;
    logic [NUM_W-1:0]  num;
    logic [GAIN_W-1:0] quo;

    function automatic logic [EXT_W-1:0] ext_f(input logic [RAW_W-1:0] v, input logic bip);
        return {bip & v[RAW_W-1], v};
    endfunction

    always_comb begin
        raw_e     = ext_f(raw_i, bipolar_i);
        off_e     = ext_f(q.offset, bipolar_i);
        span      = {raw_e[EXT_W-1], raw_e} - {off_e[EXT_W-1], off_e};
        span_pos  = !span[SPAN_W-1] && (|span);
        host_off  = reg_we_i && (reg_sel_i == SEL_OFFSET);
        host_gain = reg_we_i && (reg_sel_i == SEL_GAIN);
        start     = cal_full_i && span_pos && !host_gain;
        target    = bipolar_i ? {1'b0, {(RAW_W-1){1'b1}}} : {RAW_W{1'b1}};
        num       = {target, {GAIN_FRAC{1'b0}}};

        d = q;
        if (host_off)        d.offset = reg_wdata_i[RAW_W-1:0];
        else if (cal_zero_i) d.offset = raw_i;
        if (host_gain)       d.gain = reg_wdata_i[GAIN_W-1:0];
        else if (div_done_o) d.gain = quo;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.offset <= '0;
            q.gain   <= GAIN_W'(1) << GAIN_FRAC;
        end else begin
            q <= d;
        end
    end

    adc_corr_div #(
        .DEN_W(DEN_W),
        .NUM_W(NUM_W),
        .Q_W  (GAIN_W)
    ) u_div (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .cancel_i(host_gain),
        .num_i   (num),
        .den_i   (span[DEN_W-1:0]),
        .busy_o  (div_busy_o),
        .done_o  (div_done_o),
        .quo_o   (quo)
    );

    assign offset_o = q.offset;
    assign gain_o   = q.gain;

endmodule

// File: rtl/adc_corr_pipe.sv
module adc_corr_pipe
    import adc_corr_pkg::*;
#(
    parameter int RAW_W     = DEF_RAW_W,
    parameter int GAIN_W    = DEF_GAIN_W,
    parameter int GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int LO_W      = DEF_LO_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic              bipolar_i,
    input  logic              narrow_i,
    input  logic [RAW_W-1:0]  offset_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic              valid_o,
    output logic [RAW_W-1:0]  data_o
);

    localparam int EXT_W  = RAW_W + 1;
    localparam int DIFF_W = RAW_W + 2;
    localparam int PROD_W = DIFF_W + GAIN_W + 1;
    localparam int RND_W  = PROD_W + 1;
    localparam int SH_HI  = GAIN_FRAC;
    localparam int SH_LO  = GAIN_FRAC + RAW_W - LO_W;

    typedef struct packed {
        logic              v;
        logic              bip;
        logic              nar;
        logic [DIFF_W-1:0] diff;
        logic [GAIN_W-1:0] gain;
    } st1_t;

    typedef struct packed {
        logic              v;
        logic              bip;
        logic              nar;
        logic [PROD_W-1:0] prod;
    } st2_t;

    typedef struct packed {
        logic             v;
        logic [RAW_W-1:0] data;
    } st3_t;

    typedef struct packed {
        st1_t s1;
        st2_t s2;
        st3_t s3;
    } pipe_t;

    pipe_t q, d;

    logic [EXT_W-1:0]         xe, oe;
    logic signed [PROD_W-1:0] a_s, b_s, p_s;
    logic signed [RND_W-1:0]  pw, half, rnd, hi, lo, clip;
    logic signed [RND_W-1:0]  one_s;
    int                       sh, n;

    function automatic logic [EXT_W-1:0] ext_f(input logic [RAW_W-1:0] v, input logic bip);
        return {bip & v[RAW_W-1], v};
    endfunction

    always_comb begin
        d     = q;
        one_s = RND_W'(1);

        // stage 1: subtract offset, capture gain with the sample
        xe      = ext_f(raw_i, bipolar_i);
        oe      = ext_f(offset_i, bipolar_i);
        d.s1.v  = valid_i;
        if (valid_i) begin
            d.s1.diff = {xe[EXT_W-1], xe} - {oe[EXT_W-1], oe};
            d.s1.gain = gain_i;
            d.s1.bip  = bipolar_i;
            d.s1.nar  = narrow_i;
        end

        // stage 2: full-precision multiply
        a_s    = {{(PROD_W-DIFF_W){q.s1.diff[DIFF_W-1]}}, q.s1.diff};
        b_s    = {{(PROD_W-GAIN_W){1'b0}}, q.s1.gain};
        p_s    = a_s * b_s;
        d.s2.v = q.s1.v;
        if (q.s1.v) begin
            d.s2.prod = p_s;
            d.s2.bip  = q.s1.bip;
            d.s2.nar  = q.s1.nar;
        end

        // stage 3: round half up, then clip to the coding range
        sh   = q.s2.nar ? SH_LO : SH_HI;
        n    = q.s2.nar ? LO_W : RAW_W;
        pw   = {q.s2.prod[PROD_W-1], q.s2.prod};
        half = one_s <<< (sh - 1);
        rnd  = (pw + half) >>> sh;
        hi   = q.s2.bip ? (one_s <<< (n - 1)) - one_s : (one_s <<< n) - one_s;
        lo   = q.s2.bip ? -(one_s <<< (n - 1)) : '0;
        if (rnd > hi)      clip = hi;
        else if (rnd < lo) clip = lo;
        else               clip = rnd;
        d.s3.v = q.s2.v;
        if (q.s2.v) begin
            if (q.s2.nar) d.s3.data = {{(RAW_W-LO_W){1'b0}}, clip[LO_W-1:0]};
            else          d.s3.data = clip[RAW_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign valid_o = q.s3.v;
    assign data_o  = q.s3.data;

endmodule

// File: rtl/adc_corr.sv
module adc_corr
    import adc_corr_pkg::*;
#(
    parameter int RAW_W     = DEF_RAW_W,
    parameter int GAIN_W    = DEF_GAIN_W,
    parameter int GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int LO_W      = DEF_LO_W,
    parameter int DATA_W    = (RAW_W > GAIN_W) ? RAW_W : GAIN_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bipolar_i,
    input  logic              narrow_i,
    input  logic              raw_valid_i,
    input  logic [RAW_W-1:0]  raw_i,
    input  logic              cal_zero_i,
    input  logic              cal_full_i,
    input  logic              reg_we_i,
    input  logic              reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic              out_valid_o,
    output logic [RAW_W-1:0]  out_data_o
);

    logic [RAW_W-1:0]  offset_w;
    logic [GAIN_W-1:0] gain_w;
    logic              div_busy_w;
    logic              div_done_w;

    adc_corr_coef #(
        .RAW_W    (RAW_W),
        .GAIN_W   (GAIN_W),
        .GAIN_FRAC(GAIN_FRAC),
        .DATA_W   (DATA_W)
    ) u_coef (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bipolar_i  (bipolar_i),
        .raw_i      (raw_i),
        .cal_zero_i (cal_zero_i),
        .cal_full_i (cal_full_i),
        .reg_we_i   (reg_we_i),
        .reg_sel_i  (reg_sel_i),
        .reg_wdata_i(reg_wdata_i),
        .offset_o   (offset_w),
        .gain_o     (gain_w),
        .div_busy_o (div_busy_w),
        .div_done_o (div_done_w)
    );

    adc_corr_pipe #(
        .RAW_W    (RAW_W),
        .GAIN_W   (GAIN_W),
        .GAIN_FRAC(GAIN_FRAC),
        .LO_W     (LO_W)
    ) u_pipe (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (raw_valid_i),
        .raw_i    (raw_i),
        .bipolar_i(bipolar_i),
        .narrow_i (narrow_i),
        .offset_i (offset_w),
        .gain_i   (gain_w),
        .valid_o  (out_valid_o),
        .data_o   (out_data_o)
    );

endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
    parameter int RAW_W  = 24,
    parameter int GAIN_W = 24,
    parameter int LO_W   = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              raw_valid_i,
    input logic [RAW_W-1:0]  raw_i,
    input logic              narrow_i,
    input logic              cal_zero_i,
    input logic              reg_we_i,
    input logic              reg_sel_i,
    input logic              out_valid_o,
    input logic [RAW_W-1:0]  out_data_o,
    input logic [RAW_W-1:0]  offset_w,
    input logic [GAIN_W-1:0] gain_w,
    input logic              div_busy_w,
    input logic              div_done_w
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i)
        !rst_ni |=> (!out_valid_o && out_data_o == '0));

    // R2
    valid_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        raw_valid_i |=> ##2 out_valid_o);

    // R2
    valid_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        out_valid_o |-> $past(raw_valid_i, 3));

    // R4
    narrow_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && $past(narrow_i, 3)) |-> (out_data_o[RAW_W-1:LO_W] == '0));

    // R6
    gain_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(gain_w) |-> ($past(reg_we_i && reg_sel_i) || $past(div_done_w)));

    // R7
    zero_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(cal_zero_i && !(reg_we_i && !reg_sel_i)) |-> (offset_w == $past(raw_i)));

    // R10
    cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_we_i && reg_sel_i) |=> !div_busy_w);

endmodule

bind adc_corr adc_corr_chk #(
    .RAW_W (RAW_W),
    .GAIN_W(GAIN_W),
    .LO_W  (LO_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_valid_i(raw_valid_i),
    .raw_i      (raw_i),
    .narrow_i   (narrow_i),
    .cal_zero_i (cal_zero_i),
    .reg_we_i   (reg_we_i),
    .reg_sel_i  (reg_sel_i),
    .out_valid_o(out_valid_o),
    .out_data_o (out_data_o),
    .offset_w   (offset_w),
    .gain_w     (gain_w),
    .div_busy_w (div_busy_w),
    .div_done_w (div_done_w)
);

// File: tb/sim_adc_corr.sv
module sim_adc_corr;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        bipolar_i = 1'b0;
    logic        narrow_i = 1'b0;
    logic        raw_valid_i = 1'b0;
    logic [23:0] raw_i = '0;
    logic        cal_zero_i = 1'b0;
    logic        cal_full_i = 1'b0;
    logic        reg_we_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [23:0] reg_wdata_i = '0;
    logic        out_valid_o;
    logic [23:0] out_data_o;

    int    checks = 0;
    int    errors = 0;
    longint off_m  = 0;
    longint gain_m = 64'h400000;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    adc_corr u0 (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bipolar_i  (bipolar_i),
        .narrow_i   (narrow_i),
        .raw_valid_i(raw_valid_i),
        .raw_i      (raw_i),
        .cal_zero_i (cal_zero_i),
        .cal_full_i (cal_full_i),
        .reg_we_i   (reg_we_i),
        .reg_sel_i  (reg_sel_i),
        .reg_wdata_i(reg_wdata_i),
        .out_valid_o(out_valid_o),
        .out_data_o (out_data_o)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic longint sx(input longint v, input bit bip);
        if (bip && v >= 64'sh800000) return v - 64'sh1000000;
        return v;
    endfunction

    function automatic longint model(input longint raw, input bit bip, input bit nar);
        longint p, r, mx, mn, one;
        int sh, n;
        one = 1;
        p  = (sx(raw, bip) - sx(off_m, bip)) * gain_m;
        sh = nar ? 30 : 22;
        n  = nar ? 16 : 24;
        r  = (p + (one <<< (sh - 1))) >>> sh;
        mx = bip ? (one <<< (n - 1)) - 1 : (one <<< n) - 1;
        mn = bip ? -(one <<< (n - 1)) : 0;
        if (r > mx) r = mx;
        if (r < mn) r = mn;
        return r & ((one <<< n) - 1);
    endfunction

    // one sample, checked three edges later, strobe checked to drop after one cycle
    task automatic send_check(input longint raw, input string tag);
        longint exp;
        exp = model(raw, bipolar_i, narrow_i);
        raw_i = raw[23:0];
        raw_valid_i = 1'b1;
        @(negedge clk_i);
        raw_valid_i = 1'b0;
        @(negedge clk_i);
        @(negedge clk_i);
        check(out_valid_o == 1'b1, {tag, " R2 strobe"}, longint'(out_valid_o), 1);
        check(out_data_o == exp[23:0], tag, longint'(out_data_o), exp);
        @(negedge clk_i);
        check(out_valid_o == 1'b0, "R2 single-cycle", longint'(out_valid_o), 0);
    endtask

    task automatic wr_coef(input bit sel, input longint val);
        reg_we_i = 1'b1;
        reg_sel_i = sel;
        reg_wdata_i = val[23:0];
        @(negedge clk_i);
        reg_we_i = 1'b0;
        if (sel) gain_m = val;
        else     off_m  = val;
    endtask

    task automatic cal_zero(input longint val);
        raw_i = val[23:0];
        cal_zero_i = 1'b1;
        @(negedge clk_i);
        cal_zero_i = 1'b0;
        off_m = val;
    endtask

    task automatic cal_full(input longint val, input int wait_cycles);
        longint span, t, qv;
        raw_i = val[23:0];
        cal_full_i = 1'b1;
        @(negedge clk_i);
        cal_full_i = 1'b0;
        span = sx(val, bipolar_i) - sx(off_m, bipolar_i);
        if (span > 0) begin
            t  = bipolar_i ? 64'h7FFFFF : 64'hFFFFFF;
            qv = (t <<< 22) / span;
            if (qv > 64'hFFFFFF) qv = 64'hFFFFFF;
            gain_m = qv;
        end
        repeat (wait_cycles) @(negedge clk_i);
    endtask

    task automatic t_reset;
        check(out_valid_o == 1'b0, "R1 valid in reset", longint'(out_valid_o), 0);
        check(out_data_o == 24'h0, "R1 data in reset", longint'(out_data_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        send_check(64'h123456, "R1 passthrough");
    endtask

    task automatic t_unipolar;
        wr_coef(1'b0, 64'h000100);
        wr_coef(1'b1, 64'h600000);
        send_check(64'h001100, "R3 R6 offset and gain 1.5");
        send_check(64'h000333, "R3 rounding");
        narrow_i = 1'b1;
        wr_coef(1'b0, 64'h0);
        wr_coef(1'b1, 64'h400000);
        send_check(64'h123480, "R4 narrow round half up");
        send_check(64'h12347F, "R4 narrow round down");
        narrow_i = 1'b0;
        wr_coef(1'b0, 64'h100);
        send_check(64'h000050, "R5 unipolar clip low");
        wr_coef(1'b1, 64'h800000);
        send_check(64'h900000, "R5 unipolar clip high");
        narrow_i = 1'b1;
        send_check(64'h900000, "R5 narrow clip high");
        narrow_i = 1'b0;
    endtask

    task automatic t_bipolar;
        bipolar_i = 1'b1;
        wr_coef(1'b0, 64'h0);
        wr_coef(1'b1, 64'h400000);
        send_check(64'hFFFF00, "R3 bipolar negative");
        wr_coef(1'b1, 64'hC00000);
        send_check(64'h400000, "R5 bipolar clip high");
        send_check(64'hC00000, "R5 bipolar clip low");
        wr_coef(1'b1, 64'h400000);
        narrow_i = 1'b1;
        send_check(64'hFF0000, "R4 bipolar narrow");
        narrow_i = 1'b0;
        bipolar_i = 1'b0;
    endtask

    // R11: gain changed on the edge after acceptance
    task automatic t_inflight;
        longint exp;
        wr_coef(1'b0, 64'h0);
        wr_coef(1'b1, 64'h400000);
        exp = model(64'h010000, 1'b0, 1'b0);
        raw_i = 24'h010000;
        raw_valid_i = 1'b1;
        @(negedge clk_i);
        raw_valid_i = 1'b0;
        wr_coef(1'b1, 64'h200000);
        @(negedge clk_i);
        check(out_valid_o == 1'b1, "R11 strobe", longint'(out_valid_o), 1);
        check(out_data_o == exp[23:0], "R11 old gain kept", longint'(out_data_o), exp);
        @(negedge clk_i);
        send_check(64'h010000, "R11 new gain after");
    endtask

    task automatic t_cal;
        wr_coef(1'b1, 64'h400000);
        cal_zero(64'h001000);
        send_check(64'h001000, "R7 zero capture");
        cal_full(64'h801000, 60);
        send_check(64'h801000, "R8 unipolar full scale");
        send_check(64'h401000, "R8 unipolar mid");
        cal_zero(64'h002000);
        send_check(64'h402000, "R7 zero only keeps gain");
        cal_full(64'h002000, 60);
        send_check(64'h402000, "R9 zero span ignored");
        cal_full(64'h001000, 60);
        send_check(64'h402000, "R9 negative span ignored");
        wr_coef(1'b0, 64'h0);
        cal_full(64'h000100, 60);
        send_check(64'h000200, "R8 quotient clamp");
    endtask

    task automatic t_cancel;
        wr_coef(1'b0, 64'h0);
        cal_full(64'h800000, 5);
        wr_coef(1'b1, 64'h500000);
        repeat (60) @(negedge clk_i);
        send_check(64'h300000, "R10 host write cancels");
    endtask

    task automatic t_bipolar_cal;
        bipolar_i = 1'b1;
        cal_zero(64'hFFFFF0);
        cal_full(64'h3FFFF0, 60);
        send_check(64'h1FFFF0, "R8 bipolar half scale");
        send_check(64'hFFFFF0, "R8 bipolar midscale zero");
        bipolar_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        t_unipolar();
        t_bipolar();
        t_inflight();
        t_cal();
        t_cancel();
        t_bipolar_cal();
        repeat (3) @(negedge clk_i);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule